// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Latched Pin Interrupts

This block is a small memory-mapped port of general-purpose pins. Every pin can be set up as an input, a push-pull output or an open-drain output that can only pull its wire low. Software reaches the port through a single-cycle register bus. The block drives per-pin output-enable and output-value signals toward a tri-state pad, and takes the pad level back in through a two-flop synchronizer. The synchronized level can always be read, so software can see the true state of a wired-AND line while its own open-drain driver is released.

Each pin also has an interrupt detector. The detector watches the synchronized pin level whatever the pin direction. It can be set for edge or level sensing and for either polarity. A detected condition sets a raw status bit. That bit stays set until software clears it, and this holds in level mode too. A mask gates the raw bits into a masked status and into one port interrupt line.

The bus is word addressed by byte offset. Writes take effect on the clock edge where `bus_sel` and `bus_we` are high. A read presents its data on `bus_rdata` one cycle after `bus_sel` is high with `bus_we` low. Register offsets (bit i of each register is pin i):

| Offset | Register |
|---|---|
| 0x00 | output value (read/write) |
| 0x04 | synchronized pin level (read only) |
| 0x08 | direction, 1 = output |
| 0x0C | digital enable |
| 0x10 | open-drain select |
| 0x14 | sense, 0 = edge, 1 = level |
| 0x18 | polarity, 1 = rising/high, 0 = falling/low |
| 0x1C | mask |
| 0x20 | raw status (read only) |
| 0x24 | masked status (read only) |
| 0x28 | clear, write 1 (reads zero) |

Top module: `gpio_latch_port`

## Requirements
- R1: A write to the output value register at 0x00 changes bit i only where direction bit i (0x08) is 1. Bits of pins set as inputs keep their earlier value when read back.
- R2: An enabled push-pull output pin (enable 1, direction 1, open-drain 0) drives `pad_oe[i]`=1 and `pad_out[i]` equal to its output value, two clocks after the last configuring write.
- R3: An enabled open-drain output pin drives `pad_oe[i]` = NOT(output value) with `pad_out[i]`=0. With output value 1 the wire stays free, and another device pulling it low shows as 0 in the level register at 0x04.
- R4: A pin whose enable bit (0x0C) is 0 never drives (`pad_oe[i]`=0), reads 0 in the level register, and never sets its raw status bit.
- R5: The level register returns the pad input of each enabled pin after it passes through two synchronizing flops.
- R6: In edge mode (sense 0), polarity 1 sets raw status bit i on a rising synchronized edge, and polarity 0 sets it on a falling edge. No other pin's bit is set.
- R7: In level mode (sense 1), raw bit i is set while the pin is at the selected level (1 for polarity 1, 0 for polarity 0). The bit stays set after the level goes away.
- R8: Writing 1 to bit i of the clear register (0x28) resets raw bit i. In level mode, if the active level is still present, the bit is set again on the next clock and reads 1.
- R9: Raw status reads the same whatever the mask holds. Masked status (0x24) equals raw AND mask, and `irq` is the OR of the masked status bits, one clock later.
- R10: Offsets outside the map, and any access whose two low address bits are not zero, read as zero. A write to such an address changes nothing.
- R11: After reset every register is zero, `pad_oe` and `irq` are 0, and reads of direction and raw status return 0.
- R12: The detector also sees a pin the port drives itself. A push-pull output pin driven from 0 to 1 sets a rising-edge raw bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (6) | Byte address |
| bus_wdata | input | NPINS (8) | Write data |
| bus_rdata | output | NPINS (8) | Read data, one cycle after a read strobe |
| pad_in | input | NPINS (8) | Level seen on each pad |
| pad_oe | output | NPINS (8) | Pad output enable |
| pad_out | output | NPINS (8) | Pad output value |
| irq | output | 1 | Port interrupt, OR of masked status |

## Verification
A wrong direction or enable bit shows up at `pad_oe` two clocks after the write. A corrupted output value shows up at once in the read-back of 0x00. A raw status bit that sets wrongly or clears wrongly is seen at the first read of 0x20 after the pin moves, four clocks after the pad changes. A bad mask path shows on `irq` one clock after the raw or mask change.

// File: rtl/gpio_latch_pkg.sv
package gpio_latch_pkg;
  // word indices (byte offset / 4)
  localparam int unsigned W_OUTVAL = 0;
  localparam int unsigned W_LEVEL  = 1;
  localparam int unsigned W_DIR    = 2;
  localparam int unsigned W_EN     = 3;
  localparam int unsigned W_ODSEL  = 4;
  localparam int unsigned W_SENSE  = 5;
  localparam int unsigned W_POL    = 6;
  localparam int unsigned W_MASK   = 7;
  localparam int unsigned W_RAW    = 8;
  localparam int unsigned W_MSTAT  = 9;
  localparam int unsigned W_CLEAR  = 10;

  typedef enum logic {SENSE_EDGE = 1'b0, SENSE_LEVEL = 1'b1} sense_e;

  // detection condition for one pin
  function automatic logic det_hit(logic lvl, logic prev, sense_e sense, logic pol);
    if (sense == SENSE_LEVEL) return pol ? lvl : ~lvl;
    return pol ? (lvl & ~prev) : (~lvl & prev);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) st[k] <= '0;
    end else begin
      st[0] <= d;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_pad_drv.sv
module gpio_pad_drv (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic dir,
  input  logic od,
  input  logic val,
  output logic oe,
  output logic out
);
  logic drive;
  assign drive = en & dir;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe  <= 1'b0;
      out <= 1'b0;
    end else if (od) begin
      oe  <= drive & ~val;   // only ever pulls low
      out <= 1'b0;
    end else begin
      oe  <= drive;
      out <= drive & val;
    end
  end
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
  import gpio_latch_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic prev,
  input  logic en,
  input  logic sense,
  input  logic pol,
  input  logic clr,
  output logic raw
);
  logic hit;
  assign hit = en & det_hit(lvl, prev, sense_e'(sense), pol);

  // a live condition wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) raw <= 1'b0;
    else     raw <= (raw & ~clr) | hit;
  end
endmodule

// File: rtl/gpio_latch_port.sv
module gpio_latch_port
  import gpio_latch_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int AW    = 6,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out,
  output logic             irq
);
  localparam int IW = AW - 2;

  logic [NPINS-1:0] outval_q, dir_q, en_q, od_q, sense_q, pol_q, mask_q;
  logic [NPINS-1:0] lvl, prev_q, raw, clr_bits, rd_mux;
  logic [IW-1:0]    word;
  logic             aligned, wr, rd;

  assign word    = bus_addr[AW-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr      = bus_sel & bus_we & aligned;
  assign rd      = bus_sel & ~bus_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      outval_q <= '0; dir_q <= '0; en_q <= '0; od_q <= '0;
      sense_q  <= '0; pol_q <= '0; mask_q <= '0;
    end else if (wr) begin
      case (word)
        IW'(W_OUTVAL): outval_q <= (outval_q & ~dir_q) | (bus_wdata & dir_q);
        IW'(W_DIR):    dir_q    <= bus_wdata;
        IW'(W_EN):     en_q     <= bus_wdata;
        IW'(W_ODSEL):  od_q     <= bus_wdata;
        IW'(W_SENSE):  sense_q  <= bus_wdata;
        IW'(W_POL):    pol_q    <= bus_wdata;
        IW'(W_MASK):   mask_q   <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign clr_bits = (wr && word == IW'(W_CLEAR)) ? bus_wdata : '0;

  // input path: disabled pins do not sample
  gpio_sync #(.W(NPINS), .STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in & en_q), .q(lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_pad_drv u_drv (
      .clk(clk), .rst(rst), .en(en_q[i]), .dir(dir_q[i]), .od(od_q[i]),
      .val(outval_q[i]), .oe(pad_oe[i]), .out(pad_out[i])
    );
    gpio_irq_cell u_irq (
      .clk(clk), .rst(rst), .lvl(lvl[i]), .prev(prev_q[i]), .en(en_q[i]),
      .sense(sense_q[i]), .pol(pol_q[i]), .clr(clr_bits[i]), .raw(raw[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      case (word)
        IW'(W_OUTVAL): rd_mux = outval_q;
        IW'(W_LEVEL):  rd_mux = lvl;
        IW'(W_DIR):    rd_mux = dir_q;
        IW'(W_EN):     rd_mux = en_q;
        IW'(W_ODSEL):  rd_mux = od_q;
        IW'(W_SENSE):  rd_mux = sense_q;
        IW'(W_POL):    rd_mux = pol_q;
        IW'(W_MASK):   rd_mux = mask_q;
        IW'(W_RAW):    rd_mux = raw;
        IW'(W_MSTAT):  rd_mux = raw & mask_q;
        default:       rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (rd) bus_rdata <= rd_mux;
      irq <= |(raw & mask_q);
    end
  end
endmodule

// File: rtl/gpio_latch_port_chk.sv
module gpio_latch_port_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_out,
  input logic             irq,
  input logic [NPINS-1:0] outval_q,
  input logic [NPINS-1:0] dir_q,
  input logic [NPINS-1:0] en_q,
  input logic [NPINS-1:0] od_q,
  input logic [NPINS-1:0] mask_q,
  input logic [NPINS-1:0] raw,
  input logic [NPINS-1:0] clr_bits
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (pad_oe == '0 && !irq)); // R11

  AST_INPUT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (((outval_q ^ $past(outval_q)) & ~$past(dir_q)) == '0)); // R1

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe & pad_out & $past(od_q)) == '0)); // R3

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe & ~$past(en_q)) == '0)); // R4

  AST_RAW_STICKY: assert property (@(posedge clk) disable iff (rst)
    ((($past(raw) & ~$past(clr_bits)) & ~raw) == '0)); // R7

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (irq == (|($past(raw) & $past(mask_q))))); // R9
endmodule

bind gpio_latch_port gpio_latch_port_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst(rst), .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq),
  .outval_q(outval_q), .dir_q(dir_q), .en_q(en_q), .od_q(od_q),
  .mask_q(mask_q), .raw(raw), .clr_bits(clr_bits)
);

// File: tb/gpio_latch_port_test.sv
module gpio_latch_port_test;
  localparam int N = 8;
  localparam logic [5:0] A_OUT = 6'h00, A_LVL = 6'h04, A_DIR = 6'h08, A_EN = 6'h0C,
    A_OD = 6'h10, A_SNS = 6'h14, A_POL = 6'h18, A_MSK = 6'h1C, A_RAW = 6'h20,
    A_MST = 6'h24, A_CLR = 6'h28;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata, pad_oe, pad_out, pad_in;
  logic irq;
  logic [N-1:0] ext = '1;   // external level when the pad is not driven
  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_latch_port uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #2_000_000ns;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v, model;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk("R11 pad_oe", pad_oe, 0);
    chk("R11 irq", irq, 0);
    rd(A_DIR, v); chk("R11 dir", v, 0);
    rd(A_RAW, v); chk("R11 raw", v, 0);

    // R1 sweep over every direction pattern
    model = '0;
    for (int d = 0; d < 256; d++) begin
      logic [N-1:0] wv;
      wv = N'((d * 73 + 41) & 8'hFF);
      wr(A_DIR, N'(d));
      wr(A_OUT, wv);
      model = (model & ~N'(d)) | (wv & N'(d));
      rd(A_OUT, v);
      chk("R1 outval readback", v, model);
    end

    // R2 push-pull
    wr(A_EN, 8'hFF); wr(A_OD, 8'h00); wr(A_DIR, 8'hFF); wr(A_OUT, 8'hA5); settle();
    chk("R2 oe all", pad_oe, 8'hFF);
    chk("R2 out", pad_out, 8'hA5);
    wr(A_DIR, 8'h0F); settle();
    chk("R2 oe low nibble", pad_oe, 8'h0F);
    chk("R2 out low nibble", pad_out, 8'h05);

    // R3 open drain and wired-AND
    wr(A_DIR, 8'hFF); wr(A_OD, 8'hFF); wr(A_OUT, 8'h3C); ext = '1; settle();
    chk("R3 oe", pad_oe, 8'hC3);
    chk("R3 out", pad_out, 8'h00);
    rd(A_LVL, v); chk("R3 level released", v, 8'h3C);
    ext = ~8'h04; settle();
    rd(A_LVL, v); chk("R3 level pulled by other device", v, 8'h38);
    ext = '1;

    // R4 disabled pins
    wr(A_OD, 8'h00); wr(A_OUT, 8'hFF); wr(A_EN, 8'h0F); settle();
    chk("R4 oe only enabled", pad_oe, 8'h0F);
    wr(A_DIR, 8'h00); settle();
    rd(A_LVL, v); chk("R4 level disabled reads 0", v, 8'h0F);
    wr(A_SNS, 8'hFF); wr(A_POL, 8'h00); ext = 8'h00; settle();
    wr(A_CLR, 8'hFF); settle();
    rd(A_RAW, v); chk("R4 low level only on enabled", v, 8'h0F);
    wr(A_SNS, 8'h00); ext = '1; wr(A_EN, 8'hFF); settle(); wr(A_CLR, 8'hFF); settle();

    // R5 level after sync
    ext = 8'h96; settle();
    rd(A_LVL, v); chk("R5 level", v, 8'h96);

    // R6 / R7 / R8 / R9 sweep: every pin, every sense/polarity combination
    for (int i = 0; i < N; i++) begin
      for (int m = 0; m < 4; m++) begin
        logic sns, pl;
        logic [N-1:0] idle, bit_i;
        sns = m[1]; pl = m[0];
        bit_i = N'(1) << i;
        idle = pl ? 8'h00 : 8'hFF;
        wr(A_MSK, 8'h00);
        ext = idle; settle();
        wr(A_SNS, sns ? 8'hFF : 8'h00); wr(A_POL, pl ? 8'hFF : 8'h00); settle();
        wr(A_CLR, 8'hFF); settle();
        rd(A_RAW, v); chk(sns ? "R7 idle raw" : "R6 idle raw", v, 0);
        ext = idle ^ bit_i; settle();
        rd(A_RAW, v); chk(sns ? "R7 level set" : "R6 edge set", v, bit_i);
        wr(A_MSK, N'(1) << ((i + 1) % N)); settle();
        rd(A_RAW, v); chk("R9 raw unmasked", v, bit_i);
        rd(A_MST, v); chk("R9 mstat masked off", v, 0);
        chk("R9 irq off", irq, 0);
        wr(A_MSK, bit_i); settle();
        rd(A_MST, v); chk("R9 mstat", v, bit_i);
        chk("R9 irq on", irq, 1);
        if (sns) begin
          wr(A_CLR, bit_i); settle();
          rd(A_RAW, v); chk("R8 clear while active", v, bit_i);
        end
        ext = idle; settle();
        rd(A_RAW, v); chk(sns ? "R7 sticky after level gone" : "R6 sticky", v, bit_i);
        wr(A_CLR, bit_i); settle();
        rd(A_RAW, v); chk("R8 cleared", v, 0);
        chk("R9 irq cleared", irq, 0);
      end
    end

    // R10 unmapped and misaligned
    rd(6'h2C, v); chk("R10 unmapped", v, 0);
    rd(6'h3C, v); chk("R10 unmapped top", v, 0);
    rd(6'h09, v); chk("R10 misaligned read", v, 0);
    wr(6'h0A, 8'h55);
    rd(A_DIR, v); chk("R10 misaligned write ignored", v, 8'h00);

    // R12 own output seen by detector
    wr(A_MSK, 8'h00); wr(A_SNS, 8'h00); wr(A_POL, 8'hFF);
    wr(A_OD, 8'h00); ext = 8'h00; wr(A_DIR, 8'h01); wr(A_OUT, 8'h00); settle();
    wr(A_CLR, 8'hFF); settle();
    wr(A_OUT, 8'h01); settle();
    rd(A_RAW, v); chk("R12 driven edge", v, 8'h01);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule